// File: doc/BRIEF.md
# Page-Granular Address Translator with Protection

This block turns a 32-bit virtual address into a 28-bit physical address at 64 KB page granularity. The upper sixteen address bits select an entry of a small page table kept in on-chip registers; the entry supplies a 12-bit physical page number that is joined with the untouched 16-bit page offset. Each entry also holds a presence flag, a modified (dirty) flag and three access permissions, so every lookup both translates and polices the access.

A requester presents an address and an access kind (data read, data write or instruction fetch) with a one-cycle request strobe. One cycle later the block answers with a response strobe and either the physical address or a nonzero fault cause. Software fills the table through a separate load port that replaces a whole entry on a clock edge. Servicing a fault, swapping pages and caching translations are left to the surrounding system.

Top module: `xlat_unit`

## Requirements
- R1: After reset rsp_valid, rsp_cause, rsp_paddr and rsp_dirty are 0 and every entry is absent, so any access until an entry is loaded reports cause 2'b01.
- R2: A request sampled on a clock edge with req_valid high yields rsp_valid high for exactly the following cycle; with req_valid low rsp_valid stays low, and while rsp_valid is low rsp_cause and rsp_paddr are 0.
- R3: On a successful lookup rsp_paddr[27:16] equals the entry's page number and rsp_paddr[15:0] equals req_vaddr[15:0] unchanged.
- R4: req_vaddr[31:16] selects the entry; a page number at or above NUM_ENT (64 by default) reports cause 2'b01.
- R5: An access to an entry whose presence flag is clear reports cause 2'b01; any fault returns rsp_paddr and rsp_dirty as 0.
- R6: req_kind 2'b00 is a read needing permission bit 0 (R), 2'b01 a write needing bit 1 (W), 2'b10 a fetch needing bit 2 (X), and 2'b11 is handled as a read; a denied read or write reports cause 2'b10, a denied fetch 2'b11, success 2'b00.
- R7: An absent entry reports 2'b01 even when the access would also break its permissions.
- R8: A successful write sets the entry's dirty flag on the edge that registers its response; rsp_dirty shows the flag as it stood when the lookup was made; a faulted write leaves it unchanged.
- R9: With wr_en high, the entry at wr_idx takes wr_ppn, wr_present and wr_perm and has its dirty flag cleared on the clock edge; a lookup in that same cycle sees the earlier contents.
- R10: When a load and a dirty-setting write hit the same entry in one cycle, the load wins and the dirty flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| wr_en | input | 1 | Entry load strobe |
| wr_idx | input | 6 | Entry to load |
| wr_ppn | input | 12 | Physical page number to load |
| wr_present | input | 1 | Presence flag to load |
| wr_perm | input | 3 | Permissions to load: bit 0 R, bit 1 W, bit 2 X |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 28 | Physical address, 0 on a fault |
| rsp_cause | output | 2 | 00 none, 01 absent, 10 data protection, 11 fetch protection |
| rsp_dirty | output | 1 | Dirty flag of the entry at lookup time |

## Verification
The bound checker watches on every cycle that a response follows each request by exactly one cycle, that idle cycles and faults carry zeroed data, that the page offset of a good translation matches the request, that an out-of-range page number faults as absent, and that a fetch never comes back with the data-protection cause. Which cause a given entry and access kind produce, whether the dirty flag is set or left alone, and how a load and a lookup in the same cycle interact depend on table contents loaded earlier, so only the bench's scenarios with their precomputed answers can show them.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_DPROT  = 2'b10,
    CAUSE_XPROT  = 2'b11
  } cause_e;

  typedef struct packed {
    logic present;
    logic dirty;
    logic rd;
    logic wr;
    logic ex;
  } pte_flags_t;

endpackage

// File: rtl/xlat_pt_regs.sv
module xlat_pt_regs
  import xlat_pkg::*;
#(
  parameter int NUM_ENT = 64,
  parameter int PPN_W   = 12,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_present,
  input  logic [2:0]       wr_perm,
  input  logic             dset_en,
  input  logic [IDX_W-1:0] dset_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn,
  output pte_flags_t       rd_flags
);

  logic [PPN_W-1:0] ppn_all [NUM_ENT];
  pte_flags_t       flg_all [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [PPN_W-1:0] ppn_q, ppn_d;
    pte_flags_t       flg_q, flg_d;
    logic             load, mark;

    assign load = wr_en   && (wr_idx   == IDX_W'(g));
    assign mark = dset_en && (dset_idx == IDX_W'(g));

    // Load port takes priority over the dirty update
    always_comb begin
      ppn_d = ppn_q;
      flg_d = flg_q;
      if (load) begin
        ppn_d = wr_ppn;
        flg_d = '{present: wr_present, dirty: 1'b0,
                  rd: wr_perm[0], wr: wr_perm[1], ex: wr_perm[2]};
      end else if (mark) begin
        flg_d.dirty = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ppn_q <= '0;
        flg_q <= '0;
      end else if (load || mark) begin
        ppn_q <= ppn_d;
        flg_q <= flg_d;
      end
    end

    assign ppn_all[g] = ppn_q;
    assign flg_all[g] = flg_q;
  end

  assign rd_ppn   = ppn_all[rd_idx];
  assign rd_flags = flg_all[rd_idx];

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic       in_range,
  input  pte_flags_t flags,
  input  acc_kind_e  kind,
  output cause_e     cause
);

  always_comb begin
    if (!in_range || !flags.present) begin
      cause = CAUSE_ABSENT;
    end else begin
      unique case (kind)
        ACC_WRITE: cause = flags.wr ? CAUSE_NONE : CAUSE_DPROT;
        ACC_FETCH: cause = flags.ex ? CAUSE_NONE : CAUSE_XPROT;
        default:   cause = flags.rd ? CAUSE_NONE : CAUSE_DPROT;
      endcase
    end
  end

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFS_W   = 16,
  parameter int NUM_ENT = 64,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_present,
  input  logic [2:0]       wr_perm,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_cause,
  output logic             rsp_dirty
);

  logic [VPN_W-1:0] vpn;
  logic             in_range;
  logic [IDX_W-1:0] idx;
  acc_kind_e        kind;
  cause_e           cause;
  logic [PPN_W-1:0] lk_ppn;
  pte_flags_t       lk_flags;
  logic             dset_en;

  assign vpn      = req_vaddr[VA_W-1:OFS_W];
  assign in_range = vpn < VPN_W'(NUM_ENT);
  assign idx      = vpn[IDX_W-1:0];
  assign kind     = acc_kind_e'(req_kind);

  xlat_pt_regs #(.NUM_ENT(NUM_ENT), .PPN_W(PPN_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_ppn     (wr_ppn),
    .wr_present (wr_present),
    .wr_perm    (wr_perm),
    .dset_en    (dset_en),
    .dset_idx   (idx),
    .rd_idx     (idx),
    .rd_ppn     (lk_ppn),
    .rd_flags   (lk_flags)
  );

  xlat_perm_check u_perm (
    .in_range (in_range),
    .flags    (lk_flags),
    .kind     (kind),
    .cause    (cause)
  );

  assign dset_en = req_valid && (cause == CAUSE_NONE) && (kind == ACC_WRITE);

  // Response next state
  logic            valid_d, dirty_d;
  logic [PA_W-1:0] paddr_d;
  logic [1:0]      cause_d;

  always_comb begin
    valid_d = req_valid;
    paddr_d = '0;
    dirty_d = 1'b0;
    cause_d = CAUSE_NONE;
    if (req_valid) begin
      cause_d = cause;
      if (cause == CAUSE_NONE) begin
        paddr_d = {lk_ppn, req_vaddr[OFS_W-1:0]};
        dirty_d = lk_flags.dirty;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_cause <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_paddr <= paddr_d;
      rsp_cause <= cause_d;
      rsp_dirty <= dirty_d;
    end
  end

endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFS_W   = 16,
  parameter int NUM_ENT = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_kind,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_cause,
  input logic            rsp_dirty
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_cause == 2'b00 && rsp_paddr == '0));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_cause != 2'b00 ||
                   rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])));

  // R4
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_vaddr[VA_W-1:OFS_W] >= (VA_W-OFS_W)'(NUM_ENT)))
      |=> rsp_cause == 2'b01);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause != 2'b00 |-> (rsp_paddr == '0 && !rsp_dirty));

  // R6
  fetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b10) |=> rsp_cause != 2'b10);

endmodule

bind xlat_unit xlat_unit_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .NUM_ENT(NUM_ENT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .req_kind  (req_kind),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_cause (rsp_cause),
  .rsp_dirty (rsp_dirty)
);

// File: tb/xlat_unit_tb.sv
module xlat_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [11:0] wr_ppn = '0;
  logic        wr_present = 1'b0;
  logic [2:0]  wr_perm = '0;
  logic        rsp_valid;
  logic [27:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic        rsp_dirty;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xlat_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ppn(wr_ppn),
    .wr_present(wr_present), .wr_perm(wr_perm),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_cause(rsp_cause), .rsp_dirty(rsp_dirty)
  );

  // {kind[1:0], vaddr[31:0], cause[1:0], paddr[27:0], dirty}
  localparam int NV = 18;
  localparam logic [64:0] VEC [NV] = '{
    {2'b00, 32'h0000_1234, 2'b00, 28'h123_1234, 1'b0}, // R3 read ok
    {2'b01, 32'h0000_0010, 2'b10, 28'h0,        1'b0}, // R6 write denied
    {2'b10, 32'h0000_0020, 2'b11, 28'h0,        1'b0}, // R6 fetch denied
    {2'b00, 32'h0000_0000, 2'b00, 28'h123_0000, 1'b0}, // R8 faulted write left clean
    {2'b00, 32'h0001_ABCD, 2'b00, 28'h456_ABCD, 1'b0}, // R3
    {2'b01, 32'h0001_0004, 2'b00, 28'h456_0004, 1'b0}, // R8 write sets dirty
    {2'b00, 32'h0001_FFFF, 2'b00, 28'h456_FFFF, 1'b1}, // R8 dirty seen
    {2'b10, 32'h0001_0000, 2'b11, 28'h0,        1'b0}, // R6
    {2'b10, 32'h0002_8000, 2'b00, 28'hABC_8000, 1'b0}, // R6 fetch ok
    {2'b01, 32'h0002_0000, 2'b10, 28'h0,        1'b0}, // R6
    {2'b11, 32'h0002_0001, 2'b00, 28'hABC_0001, 1'b0}, // R6 kind 11 as read
    {2'b00, 32'h0003_0000, 2'b01, 28'h0,        1'b0}, // R5 absent entry
    {2'b01, 32'h0004_0000, 2'b01, 28'h0,        1'b0}, // R7 absent beats protect
    {2'b00, 32'h0040_0000, 2'b01, 28'h0,        1'b0}, // R4 first out of range
    {2'b00, 32'hFFFF_0000, 2'b01, 28'h0,        1'b0}, // R4
    {2'b01, 32'h003F_0001, 2'b00, 28'hFED_0001, 1'b0}, // R4 last entry
    {2'b00, 32'h0005_0000, 2'b01, 28'h0,        1'b0}, // R1 never loaded
    {2'b00, 32'h003F_8000, 2'b00, 28'hFED_8000, 1'b1}  // R8
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(int idx, logic [11:0] ppn, logic pres, logic [2:0] perm);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_ppn = ppn;
    wr_present = pres; wr_perm = perm;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drive one request, return sampled response one cycle later
  task automatic access(logic [1:0] kind, logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk_rsp(string tag, logic [1:0] c, logic [27:0] pa, logic d);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " cause"}, 32'(rsp_cause), 32'(c));
    chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    chk({tag, " dirty"}, 32'(rsp_dirty), 32'(d));
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 rsp_cause", 32'(rsp_cause), 32'd0);
    chk("R1 rsp_paddr", 32'(rsp_paddr), 32'd0);
    access(2'b00, 32'h0000_0000);
    chk_rsp("R1 empty table", 2'b01, 28'h0, 1'b0);

    load(0,  12'h123, 1'b1, 3'b001);
    load(1,  12'h456, 1'b1, 3'b011);
    load(2,  12'hABC, 1'b1, 3'b101);
    load(3,  12'h7FF, 1'b0, 3'b111);
    load(4,  12'h111, 1'b0, 3'b000);
    load(63, 12'hFED, 1'b1, 3'b111);

    // R2 idle cycle gives no response
    @(negedge clk);
    chk("R2 idle", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][64:63], VEC[i][62:31]);
      chk_rsp($sformatf("vec%0d", i), VEC[i][30:29], VEC[i][28:1], VEC[i][0]);
    end

    // R9 load and lookup of entry 1 in the same cycle: old contents seen
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_vaddr = 32'h0001_0042;
    wr_en = 1'b1; wr_idx = 6'd1; wr_ppn = 12'h999; wr_present = 1'b1; wr_perm = 3'b001;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk_rsp("R9 old contents", 2'b00, 28'h456_0042, 1'b1);
    access(2'b00, 32'h0001_0042);
    chk_rsp("R9 new contents", 2'b00, 28'h999_0042, 1'b0);
    access(2'b01, 32'h0001_0000);
    chk_rsp("R9 new perms", 2'b10, 28'h0, 1'b0);

    // R10 dirtying write and load of entry 63 collide
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01; req_vaddr = 32'h003F_0010;
    wr_en = 1'b1; wr_idx = 6'd63; wr_ppn = 12'hEEE; wr_present = 1'b1; wr_perm = 3'b011;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk_rsp("R10 collide rsp", 2'b00, 28'hFED_0010, 1'b1);
    access(2'b00, 32'h003F_0010);
    chk_rsp("R10 load wins", 2'b00, 28'hEEE_0010, 1'b0);

    // R1 reset in mid-run empties the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    access(2'b00, 32'h0000_1234);
    chk_rsp("R1 table cleared", 2'b01, 28'h0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule